// File: doc/BRIEF.md
# Inbound Serial Frame Transmitter

This block drives one point-to-point serial data line from a device towards a link controller. Each time the frame-sync pulse is seen on a rising clock edge, it takes a snapshot of the pending response word and sample data. From that edge on it sends one bit per rising edge. A frame starts with a fixed 36-bit response field. When at least one sample block is pending, a self-describing stream section follows. This section has a 4-bit stream tag, then a 6-bit length in bytes, then the sample blocks back to back. Zeros are added after the blocks up to the next byte boundary. After that the line stays low until the next sync pulse.

A sample block holds `CHANNELS` samples of `SAMPLE_BITS` bits each. Up to `MAX_BLOCKS` blocks can go in one frame, so a stream faster than the frame rate carries several blocks per frame. The sample port is one flat vector. Block 0 sits in its most significant slice. Inside a block, channel 0 is the most significant sample. Bits on the line follow the same order, from the top of the vector down. With the default parameters a block is 36 bits, so an odd block count needs 4 pad bits.

Top module: `inbound_frame_tx`

## Requirements
- R1: While reset is held, and after it until the first sync pulse, `sdi` is 0.
- R2: On the rising edge that samples `frame_sync` high, `sdi` takes frame bit 0. Each later edge advances one bit. Bits 0 to 35 are `rsp_word`, bit 35 first, when `rsp_valid` was 1 at that edge.
- R3: When `rsp_valid` was 0 at the sync edge, bits 0 to 35 are all 0.
- R4: When the effective block count is above 0, bits 36 to 39 carry `stream_tag`, bit 3 first.
- R5: Bits 40 to 45 carry the payload length in bytes, MSB first. The value is ceil(count x CHANNELS x SAMPLE_BITS / 8), so it includes the pad.
- R6: The payload starts at bit 46. It goes block 0 first, and channel 0 first inside each block. Each sample goes MSB first. Block b, channel c is read from `sample_data[PAY_W-1-(b*CHANNELS+c)*SAMPLE_BITS -: SAMPLE_BITS]`.
- R7: Pad bits up to the byte boundary are 0. Blocks at or above the count are never sent, whatever their content.
- R8: After the last bit of the stream section, `sdi` stays 0 until the next sync pulse.
- R9: When the effective block count is 0, no tag or length is sent: `sdi` is 0 from bit 36 onward.
- R10: A `blk_count` above `MAX_BLOCKS` is treated as `MAX_BLOCKS`. Length and payload then match a count of `MAX_BLOCKS`.
- R11: Inputs are sampled only at the sync edge. Changing them during a frame has no effect on that frame.
- R12: A sync pulse during a frame drops the rest of that frame. The new frame's bit 0 appears at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle pulse that starts a frame |
| rsp_valid | input | 1 | Response word is meaningful |
| rsp_word | input | RESP_BITS (36) | Response word |
| stream_tag | input | TAG_BITS (4) | Stream identifier sent ahead of the payload |
| blk_count | input | CNT_W (3) | Number of sample blocks pending this frame |
| sample_data | input | PAY_W (144) | Sample blocks, block 0 in the top slice |
| sdi | output | 1 | Serial line to the controller |

## Verification
A new sync pulse can arrive while the previous frame is still shifting. In that cycle, reloading the frame and advancing the shift both act on the same register, and the load must win. The bench provokes this in three places. It cuts a four-block frame in its payload at bit 60, a one-block frame on its last pad bit, and a frame inside its response field at bit 10. Each cut is judged two ways: the captured head must match the old frame's expected bits, and the whole following frame must match its own expected bits from bit 0.

// File: rtl/ift_pkg.sv
package ift_pkg;

    // Number of whole bytes needed to hold a given number of bits.
    function automatic int unsigned bytes_for_bits(input int unsigned nbits);
        return (nbits + 7) / 8;
    endfunction

endpackage

// File: rtl/ift_len_calc.sv
module ift_len_calc #(
    parameter int CNT_W      = 3,
    parameter int MAX_BLOCKS = 4,
    parameter int BLOCK_BITS = 36,
    parameter int LEN_BITS   = 6
) (
    input  logic [CNT_W-1:0]    blk_count,
    output logic [CNT_W-1:0]    eff_blocks,
    output logic [LEN_BITS-1:0] len_bytes
);
    logic [15:0] pay_bits;

    always_comb begin
        if (blk_count > CNT_W'(MAX_BLOCKS)) begin
            eff_blocks = CNT_W'(MAX_BLOCKS);
        end else begin
            eff_blocks = blk_count;
        end
        pay_bits  = 16'(eff_blocks) * 16'(BLOCK_BITS);
        len_bytes = LEN_BITS'((pay_bits + 16'd7) >> 3);
    end

endmodule

// File: rtl/ift_frame_build.sv
module ift_frame_build #(
    parameter int RESP_BITS  = 36,
    parameter int TAG_BITS   = 4,
    parameter int LEN_BITS   = 6,
    parameter int CNT_W      = 3,
    parameter int MAX_BLOCKS = 4,
    parameter int BLOCK_BITS = 36,
    parameter int PAY_W      = 144,
    parameter int PAYB       = 144,
    localparam int FW        = RESP_BITS + TAG_BITS + LEN_BITS + PAYB
) (
    input  logic                 rsp_valid,
    input  logic [RESP_BITS-1:0] rsp_word,
    input  logic [TAG_BITS-1:0]  stream_tag,
    input  logic [CNT_W-1:0]     eff_blocks,
    input  logic [LEN_BITS-1:0]  len_bytes,
    input  logic [PAY_W-1:0]     sample_data,
    output logic [FW-1:0]        frame
);
    logic [PAY_W-1:0] kept;
    logic [PAYB-1:0]  pay_field;
    logic             has_stream;

    // Blocks at or above the effective count are forced to zero so that
    // the byte padding after the last sent block is zero as well.
    for (genvar b = 0; b < MAX_BLOCKS; b++) begin : g_blk
        assign kept[PAY_W-1-b*BLOCK_BITS -: BLOCK_BITS] =
            (CNT_W'(b) < eff_blocks) ? sample_data[PAY_W-1-b*BLOCK_BITS -: BLOCK_BITS]
                                     : '0;
    end

    assign has_stream = (eff_blocks != '0);
    assign pay_field  = PAYB'(kept) << (PAYB - PAY_W);

    assign frame = { (rsp_valid  ? rsp_word   : {RESP_BITS{1'b0}}),
                     (has_stream ? stream_tag : {TAG_BITS{1'b0}}),
                     (has_stream ? len_bytes  : {LEN_BITS{1'b0}}),
                     pay_field };

endmodule

// File: rtl/ift_serializer.sv
module ift_serializer #(
    parameter int FW = 190
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] frame,
    output logic          line
);
    typedef struct packed {
        logic [FW-1:0] shreg;
        logic          line;
    } ser_t;

    ser_t ser_d;
    ser_t ser_q;

    always_comb begin
        ser_d = ser_q;
        if (load) begin
            ser_d.line  = frame[FW-1];
            ser_d.shreg = frame << 1;
        end else begin
            ser_d.line  = ser_q.shreg[FW-1];
            ser_d.shreg = ser_q.shreg << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q <= '0;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign line = ser_q.line;

endmodule

// File: rtl/inbound_frame_tx.sv
module inbound_frame_tx #(
    parameter int RESP_BITS   = 36,
    parameter int TAG_BITS    = 4,
    parameter int LEN_BITS    = 6,
    parameter int SAMPLE_BITS = 12,
    parameter int CHANNELS    = 3,
    parameter int MAX_BLOCKS  = 4,
    localparam int BLOCK_BITS = SAMPLE_BITS * CHANNELS,
    localparam int PAY_W      = BLOCK_BITS * MAX_BLOCKS,
    localparam int CNT_W      = $clog2(MAX_BLOCKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_sync,
    input  logic                 rsp_valid,
    input  logic [RESP_BITS-1:0] rsp_word,
    input  logic [TAG_BITS-1:0]  stream_tag,
    input  logic [CNT_W-1:0]     blk_count,
    input  logic [PAY_W-1:0]     sample_data,
    output logic                 sdi
);
    import ift_pkg::*;

    localparam int PAYB = 8 * int'(bytes_for_bits(PAY_W));
    localparam int FW   = RESP_BITS + TAG_BITS + LEN_BITS + PAYB;

    logic [CNT_W-1:0]    eff_blocks;
    logic [LEN_BITS-1:0] len_bytes;
    logic [FW-1:0]       frame;

    ift_len_calc #(
        .CNT_W      (CNT_W),
        .MAX_BLOCKS (MAX_BLOCKS),
        .BLOCK_BITS (BLOCK_BITS),
        .LEN_BITS   (LEN_BITS)
    ) len_i (
        .blk_count  (blk_count),
        .eff_blocks (eff_blocks),
        .len_bytes  (len_bytes)
    );

    ift_frame_build #(
        .RESP_BITS  (RESP_BITS),
        .TAG_BITS   (TAG_BITS),
        .LEN_BITS   (LEN_BITS),
        .CNT_W      (CNT_W),
        .MAX_BLOCKS (MAX_BLOCKS),
        .BLOCK_BITS (BLOCK_BITS),
        .PAY_W      (PAY_W),
        .PAYB       (PAYB)
    ) build_i (
        .rsp_valid   (rsp_valid),
        .rsp_word    (rsp_word),
        .stream_tag  (stream_tag),
        .eff_blocks  (eff_blocks),
        .len_bytes   (len_bytes),
        .sample_data (sample_data),
        .frame       (frame)
    );

    ift_serializer #(
        .FW (FW)
    ) ser_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_sync),
        .frame (frame),
        .line  (sdi)
    );

endmodule

// File: rtl/ift_checker.sv
module ift_checker #(
    parameter int RESP_BITS  = 36,
    parameter int TAG_BITS   = 4,
    parameter int CNT_W      = 3,
    parameter int MAX_BLOCKS = 4,
    parameter int BLOCK_BITS = 36,
    parameter int LEN_BITS   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_sync,
    input logic                rsp_valid,
    input logic                rsp_lead,
    input logic [TAG_BITS-1:0] stream_tag,
    input logic [CNT_W-1:0]    blk_count,
    input logic                sdi
);
    logic        seen_q;
    logic        has_q;
    logic        tag_lead_q;
    logic [15:0] pos_q;
    logic [15:0] end_q;
    logic [15:0] end_c;
    logic [15:0] nblk_c;

    // Independent arithmetic for where the stream section ends.
    always_comb begin
        nblk_c = (blk_count > CNT_W'(MAX_BLOCKS)) ? 16'(MAX_BLOCKS) : 16'(blk_count);
        if (nblk_c == 16'd0) begin
            end_c = 16'(RESP_BITS);
        end else begin
            end_c = 16'(RESP_BITS + TAG_BITS + LEN_BITS)
                  + 16'(((nblk_c * 16'(BLOCK_BITS)) + 16'd7) / 16'd8) * 16'd8;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            has_q      <= 1'b0;
            tag_lead_q <= 1'b0;
            pos_q      <= '0;
            end_q      <= '0;
        end else if (frame_sync) begin
            seen_q     <= 1'b1;
            has_q      <= (nblk_c != 16'd0);
            tag_lead_q <= stream_tag[TAG_BITS-1];
            pos_q      <= '0;
            end_q      <= end_c;
        end else if (pos_q != 16'hFFFF) begin
            pos_q      <= pos_q + 16'd1;
        end
    end

    // R1: quiet line until the first frame
    a_r1_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !sdi);

    // R2, R12: response MSB appears on the edge that samples sync, also mid-frame
    a_r2_resp_lead: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync && rsp_valid |=> sdi == $past(rsp_lead));

    // R3: invalid response leads with zero
    a_r3_resp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync && !rsp_valid |=> !sdi);

    // R4: tag MSB directly after the response field
    a_r4_tag_lead: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && has_q && (pos_q == 16'(RESP_BITS)) |-> sdi == tag_lead_q);

    // R8, R9: line low after the section end
    a_r8_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && (pos_q >= end_q) |-> !sdi);

    // Length field must be able to hold the largest payload
    initial begin
        a_r5_len_fits: assert ((MAX_BLOCKS * BLOCK_BITS + 7) / 8 < (1 << LEN_BITS));
    end

endmodule

bind inbound_frame_tx ift_checker #(
    .RESP_BITS  (RESP_BITS),
    .TAG_BITS   (TAG_BITS),
    .CNT_W      (CNT_W),
    .MAX_BLOCKS (MAX_BLOCKS),
    .BLOCK_BITS (BLOCK_BITS),
    .LEN_BITS   (LEN_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .rsp_valid  (rsp_valid),
    .rsp_lead   (rsp_word[RESP_BITS-1]),
    .stream_tag (stream_tag),
    .blk_count  (blk_count),
    .sdi        (sdi)
);

// File: tb/inbound_frame_tx_tb_top.sv
`timescale 1ns/1ps
module inbound_frame_tx_tb_top;

    localparam int RB = 36;
    localparam int SB = 12;
    localparam int CH = 3;
    localparam int MB = 4;
    localparam int BB = SB * CH;
    localparam int PW = BB * MB;
    localparam int FRAME = 500;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_sync = 1'b0;
    logic          rsp_valid = 1'b0;
    logic [RB-1:0] rsp_word = '0;
    logic [3:0]    stream_tag = '0;
    logic [2:0]    blk_count = '0;
    logic [PW-1:0] sample_data = '0;
    logic          sdi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model of the frame currently expected
    int          m_cnt;
    bit          m_valid;
    logic [RB-1:0] m_rsp;
    logic [3:0]  m_tag;
    logic [11:0] m_s [MB][CH];
    bit          exp_b [FRAME];
    bit          cap_b [FRAME];

    always #2.5 clk = ~clk;

    inbound_frame_tx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_sync  (frame_sync),
        .rsp_valid   (rsp_valid),
        .rsp_word    (rsp_word),
        .stream_tag  (stream_tag),
        .blk_count   (blk_count),
        .sample_data (sample_data),
        .sdi         (sdi)
    );

    function automatic int eff_of();
        return (m_cnt > MB) ? MB : m_cnt;
    endfunction

    function automatic int bytes_of();
        return (eff_of() * BB + 7) / 8;
    endfunction

    function automatic void load_model(input int cnt, input bit valid, input int p);
        m_cnt   = cnt;
        m_valid = valid;
        m_rsp   = 36'h9A5C31E7F ^ RB'(p * 36'h1_0F0F_0F0F);
        m_tag   = 4'(cnt * 3 + p + 9);
        for (int b = 0; b < MB; b++)
            for (int c = 0; c < CH; c++)
                m_s[b][c] = 12'(((b * CH + c + 1) * 421 + p * 1237) ^ 2730);
    endfunction

    task automatic drive_model();
        rsp_valid  = m_valid;
        rsp_word   = m_rsp;
        stream_tag = m_tag;
        blk_count  = 3'(m_cnt);
        for (int b = 0; b < MB; b++)
            for (int c = 0; c < CH; c++)
                sample_data[PW-1-(b*CH+c)*SB -: SB] = m_s[b][c];
    endtask

    // 0 resp, 1 tag, 2 len, 3 payload, 4 pad, 5 tail
    function automatic int region(input int k);
        int e = eff_of();
        int by = bytes_of();
        if (k < RB) return 0;
        if (e == 0) return 5;
        if (k < RB + 4) return 1;
        if (k < RB + 10) return 2;
        if (k < RB + 10 + e * BB) return 3;
        if (k < RB + 10 + by * 8) return 4;
        return 5;
    endfunction

    function automatic void build_exp();
        int e = eff_of();
        int by = bytes_of();
        for (int k = 0; k < FRAME; k++) begin
            int r = region(k);
            bit v = 1'b0;
            if (r == 0) v = m_valid ? m_rsp[RB-1-k] : 1'b0;
            else if (r == 1) v = m_tag[3-(k-RB)];
            else if (r == 2) v = by[5-(k-RB-4)];
            else if (r == 3) begin
                int j = k - RB - 10;
                int b = j / BB;
                int c = (j % BB) / SB;
                v = m_s[b][c][SB-1-(j % SB)];
            end
            exp_b[k] = v;
            if (e < 0) exp_b[k] = 1'b0;
        end
    endfunction

    function automatic string req_of(input int r);
        case (r)
            0: return m_valid ? "R2" : "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return (eff_of() == 0) ? "R9" : "R8";
        endcase
    endfunction

    function automatic void check_frame(input string ctx, input int upto);
        for (int r = 0; r < 6; r++) begin
            bit present = 1'b0;
            int bad = -1;
            for (int k = 0; k < upto; k++) begin
                if (region(k) == r) begin
                    present = 1'b1;
                    if (bad < 0 && cap_b[k] != exp_b[k]) bad = k;
                end
            end
            if (present) begin
                n_checks++;
                if (bad >= 0) begin
                    n_fail++;
                    $display("FAIL %s %s cnt=%0d valid=%0d bit %0d: actual %0d expected %0d",
                             req_of(r), ctx, m_cnt, m_valid, bad, cap_b[bad], exp_b[bad]);
                end
            end
        end
    endfunction

    // Caller stands at a falling edge. Captures bits 0..cut-1, returns at a falling edge.
    task automatic send(input int cut, input bit scramble);
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        cap_b[0] = sdi;
        if (scramble) begin
            // R11: changes after the sync edge must not reach the line
            rsp_valid   = ~rsp_valid;
            rsp_word    = ~rsp_word;
            stream_tag  = ~stream_tag;
            blk_count   = ~blk_count;
            sample_data = ~sample_data;
        end
        for (int k = 1; k < cut; k++) begin
            @(negedge clk);
            cap_b[k] = sdi;
        end
    endtask

    task automatic run_full(input int cnt, input bit valid, input int p, input bit scr, input string ctx);
        load_model(cnt, valid, p);
        drive_model();
        build_exp();
        send(FRAME, scr);
        check_frame(ctx, FRAME);
    endtask

    task automatic run_cut(input int cnt_a, input int p_a, input int cut,
                           input int cnt_b, input int p_b, input string ctx);
        load_model(cnt_a, 1'b1, p_a);
        drive_model();
        build_exp();
        send(cut, 1'b0);
        check_frame({ctx, " R12 head"}, cut);
        load_model(cnt_b, 1'b1, p_b);
        drive_model();
        build_exp();
        send(FRAME, 1'b0);
        check_frame({ctx, " R12 restart"}, FRAME);
    endtask

    initial begin
        bit quiet;
        repeat (4) @(negedge clk);
        // garbage on inputs, no sync
        rsp_valid   = 1'b1;
        rsp_word    = '1;
        stream_tag  = 4'hF;
        blk_count   = 3'd3;
        sample_data = '1;
        rst_n = 1'b1;
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sdi !== 1'b0) quiet = 1'b0;
        end
        n_checks++;
        if (!quiet) begin
            n_fail++;
            $display("FAIL R1 line before first sync: actual 1 expected 0");
        end

        // sweep: all counts (incl. clamped R10), both valid settings, two data patterns
        for (int p = 0; p < 2; p++)
            for (int v = 0; v < 2; v++)
                for (int cnt = 0; cnt < 8; cnt++)
                    run_full(cnt, v[0], p, p[0],
                             (cnt > MB) ? (p[0] ? "R10 R11 sweep" : "R10 sweep")
                                        : (p[0] ? "R11 sweep" : "sweep"));

        // mid-frame sync: inside payload, on the last pad bit, inside response
        run_cut(4, 2, 60, 3, 3, "cut-payload");
        run_cut(1, 4, RB + 10 + 5 * 8 - 1, 2, 5, "cut-pad");
        run_cut(3, 6, 10, 0, 7, "cut-resp");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule